// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Front-End

This block is the register side of a multi-channel DMA controller. A host reaches it through a simple valid/write/address/data bus of 32-bit words. It holds five registers for each channel: source address, destination address, link pointer, control and configuration. It also holds a small set of global registers. The current channel register values go to a separate transfer engine, together with a one-cycle pulse each time a configuration register is written. The block keeps no data path of its own.

The transfer engine reports each channel's completion (terminal count) and error through one-cycle event inputs. The block latches these events into raw per-channel bits. Each channel has two enable bits in its own configuration register. These bits mask the raw bits, and the masked bits drive an error interrupt, a terminal-count interrupt and their combined OR. Software clears raw bits by writing ones to two clear registers. The `NUM_CH` parameter selects 8 or 2 channels.

The bus address is a word address: byte offset divided by four. In this document all offsets are byte offsets.

Top module: `dma_regfront`

## Requirements
- R1: After reset, every register reads as zero. The three interrupt outputs, `ctrl_enable`, `cfg_wr_pulse` and `bus_rdata` are all low.
- R2: Channel c has a window at byte 0x100 + 0x20*c. Inside the window, byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10 hold source, destination, link, control and configuration. Each of these reads back the value last written, and the same value appears on the matching `ch_*` output slice [c*32 +: 32].
- R3: Three kinds of access read as zero and leave all state unchanged: window words 5 to 7, windows with an index of `NUM_CH` or above, and global offsets not listed in these requirements (for example 0x20, 0x40, and anything from 0x200 up).
- R4: A write to 0x08 clears each raw terminal-count bit whose data bit is 1. A write to 0x10 does the same for raw error bits. Bits written as 0 keep their value.
- R5: A one-cycle `ev_tc` or `ev_err` pulse sets the raw bit of that channel. If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R6: Configuration bit 15 is the channel's terminal-count mask and bit 14 is its error mask. Offset 0x04 reads raw TC AND mask, 0x0C reads raw error AND mask, and 0x00 reads the OR of the two.
- R7: `irq_tc` is high when any masked terminal-count bit is set. `irq_err` is high when any masked error bit is set. `irq_any` is their OR.
- R8: Offset 0x1C returns configuration bit 0 of channel c at bit c, and zero above bit `NUM_CH`-1.
- R9: Offset 0x30 stores bits [2:0] and reads them back. Bit 0 drives `ctrl_enable`; bits 1 and 2 have no other effect. Offset 0x34 stores a full 32-bit word.
- R10: `cfg_wr_pulse` is high for exactly the one cycle after a write to an in-range channel configuration register or to 0x30. No other write raises it.
- R11: A read returns its data on `bus_rdata` in the cycle after the access. `bus_rdata` keeps that value until the next read.
- R12: Offset 0x14 returns the raw terminal-count bits and 0x18 the raw error bits, with no masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (byte offset / 4) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_tc | input | NUM_CH | Terminal-count events from the engine |
| ev_err | input | NUM_CH | Error events from the engine |
| ctrl_enable | output | 1 | Global controller enable |
| cfg_wr_pulse | output | 1 | Configuration-written pulse |
| ch_src | output | NUM_CH*DATA_W | Per-channel source addresses |
| ch_dst | output | NUM_CH*DATA_W | Per-channel destination addresses |
| ch_link | output | NUM_CH*DATA_W | Per-channel link pointers |
| ch_ctrl | output | NUM_CH*DATA_W | Per-channel control words |
| ch_conf | output | NUM_CH*DATA_W | Per-channel configuration words |
| irq_err | output | 1 | Masked error interrupt |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_any | output | 1 | OR of both interrupts |

## Verification
The bench latches events while the masks are off. It then checks that raw status shows the bits while the masked status and the interrupt lines stay low. A design that masked the raw bits too would hide pending events from software. The bench also fires a clear and an event on the same bit in the same cycle; a design where the clear wins would lose a completion. It writes to undefined window words, and a 2-channel instance receives a write to window 2. A loose decode would corrupt a neighbouring register or raise a spurious configuration pulse. Endianness bits are written alone, to catch a design that lets them drive the enable.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    typedef enum logic [3:0] {
        G_NONE, G_STAT_ALL, G_STAT_TC, G_CLR_TC, G_STAT_ERR, G_CLR_ERR,
        G_RAW_TC, G_RAW_ERR, G_ENABLED, G_CONF, G_SYNC
    } gsel_e;

    typedef enum logic [2:0] {
        C_SRC, C_DST, C_LINK, C_CTRL, C_CONF, C_NONE
    } csel_e;

    typedef struct packed {
        logic       hit_glob;
        gsel_e      gsel;
        logic       hit_chan;
        csel_e      csel;
        logic [2:0] chan;
    } dec_t;

    localparam int unsigned TC_MASK_BIT  = 15;
    localparam int unsigned ERR_MASK_BIT = 14;
    localparam int unsigned GCONF_W      = 3;

endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
    import dma_rf_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] waddr,
    output dec_t              dec
);
    localparam int unsigned REGION_LSB = 6;

    logic [ADDR_W-REGION_LSB-1:0] region;
    logic [5:0]                   gidx;
    logic [2:0]                   cidx;
    logic [2:0]                   cword;

    assign region = waddr[ADDR_W-1:REGION_LSB];
    assign gidx   = waddr[5:0];
    assign cidx   = waddr[5:3];
    assign cword  = waddr[2:0];

    always_comb begin
        dec      = '0;
        dec.gsel = G_NONE;
        dec.csel = C_NONE;
        dec.chan = cidx;
        if (region == '0) begin
            case (gidx)
                6'd0:    dec.gsel = G_STAT_ALL;
                6'd1:    dec.gsel = G_STAT_TC;
                6'd2:    dec.gsel = G_CLR_TC;
                6'd3:    dec.gsel = G_STAT_ERR;
                6'd4:    dec.gsel = G_CLR_ERR;
                6'd5:    dec.gsel = G_RAW_TC;
                6'd6:    dec.gsel = G_RAW_ERR;
                6'd7:    dec.gsel = G_ENABLED;
                6'd12:   dec.gsel = G_CONF;
                6'd13:   dec.gsel = G_SYNC;
                default: dec.gsel = G_NONE;
            endcase
            dec.hit_glob = (dec.gsel != G_NONE);
        end else if (region == (ADDR_W-REGION_LSB)'(1) && 32'(cidx) < NUM_CH) begin
            case (cword)
                3'd0:    dec.csel = C_SRC;
                3'd1:    dec.csel = C_DST;
                3'd2:    dec.csel = C_LINK;
                3'd3:    dec.csel = C_CTRL;
                3'd4:    dec.csel = C_CONF;
                default: dec.csel = C_NONE;
            endcase
            dec.hit_chan = (dec.csel != C_NONE);
        end
    end
endmodule

// File: rtl/dma_rf_chan_bank.sv
module dma_rf_chan_bank
    import dma_rf_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     hit_chan,
    input  csel_e                    csel,
    input  logic [2:0]               chan,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_CH*DATA_W-1:0] src_o,
    output logic [NUM_CH*DATA_W-1:0] dst_o,
    output logic [NUM_CH*DATA_W-1:0] link_o,
    output logic [NUM_CH*DATA_W-1:0] ctrl_o,
    output logic [NUM_CH*DATA_W-1:0] conf_o,
    output logic [NUM_CH-1:0]        conf_wr
);
    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] link;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] conf;
    } chan_regs_t;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_regs_t r_d, r_q;
        logic       sel;

        assign sel = wr_en && hit_chan && (chan == 3'(c));

        always_comb begin
            r_d = r_q;
            if (sel) begin
                case (csel)
                    C_SRC:   r_d.src  = wdata;
                    C_DST:   r_d.dst  = wdata;
                    C_LINK:  r_d.link = wdata;
                    C_CTRL:  r_d.ctrl = wdata;
                    C_CONF:  r_d.conf = wdata;
                    default: r_d = r_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign src_o [c*DATA_W +: DATA_W] = r_q.src;
        assign dst_o [c*DATA_W +: DATA_W] = r_q.dst;
        assign link_o[c*DATA_W +: DATA_W] = r_q.link;
        assign ctrl_o[c*DATA_W +: DATA_W] = r_q.ctrl;
        assign conf_o[c*DATA_W +: DATA_W] = r_q.conf;
        assign conf_wr[c] = sel && (csel == C_CONF);
    end
endmodule

// File: rtl/dma_rf_irq.sv
module dma_rf_irq #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_tc,
    input  logic [NUM_CH-1:0] ev_err,
    input  logic [NUM_CH-1:0] clr_tc,
    input  logic [NUM_CH-1:0] clr_err,
    input  logic [NUM_CH-1:0] tc_mask,
    input  logic [NUM_CH-1:0] err_mask,
    output logic [NUM_CH-1:0] tc_raw,
    output logic [NUM_CH-1:0] err_raw,
    output logic              irq_tc,
    output logic              irq_err,
    output logic              irq_any
);
    typedef struct packed {
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] err;
    } raw_t;

    raw_t s_d, s_q;

    always_comb begin
        s_d.tc  = (s_q.tc  & ~clr_tc)  | ev_tc;
        s_d.err = (s_q.err & ~clr_err) | ev_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tc_raw  = s_q.tc;
    assign err_raw = s_q.err;
    assign irq_tc  = |(s_q.tc  & tc_mask);
    assign irq_err = |(s_q.err & err_mask);
    assign irq_any = irq_tc | irq_err;
endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
    import dma_rf_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]        ev_tc,
    input  logic [NUM_CH-1:0]        ev_err,
    output logic                     ctrl_enable,
    output logic                     cfg_wr_pulse,
    output logic [NUM_CH*DATA_W-1:0] ch_src,
    output logic [NUM_CH*DATA_W-1:0] ch_dst,
    output logic [NUM_CH*DATA_W-1:0] ch_link,
    output logic [NUM_CH*DATA_W-1:0] ch_ctrl,
    output logic [NUM_CH*DATA_W-1:0] ch_conf,
    output logic                     irq_err,
    output logic                     irq_tc,
    output logic                     irq_any
);
    localparam int unsigned PAD_W = DATA_W - NUM_CH;

    typedef struct packed {
        logic [GCONF_W-1:0] gconf;
        logic [DATA_W-1:0]  sync;
        logic [DATA_W-1:0]  rdata;
        logic               pulse;
    } top_t;

    dec_t              dec;
    logic              wr_en, rd_en;
    logic [NUM_CH-1:0] conf_wr;
    logic [NUM_CH-1:0] tc_mask, err_mask, en_vec;
    logic [NUM_CH-1:0] clr_tc, clr_err;
    logic [NUM_CH-1:0] tc_raw_q, err_raw_q;
    logic [NUM_CH-1:0] tc_masked, err_masked;
    logic [DATA_W-1:0] rd_val;
    top_t              t_d, t_q;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    dma_rf_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .waddr (bus_addr),
        .dec   (dec)
    );

    dma_rf_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .hit_chan (dec.hit_chan),
        .csel     (dec.csel),
        .chan     (dec.chan),
        .wdata    (bus_wdata),
        .src_o    (ch_src),
        .dst_o    (ch_dst),
        .link_o   (ch_link),
        .ctrl_o   (ch_ctrl),
        .conf_o   (ch_conf),
        .conf_wr  (conf_wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        assign tc_mask[c]  = ch_conf[c*DATA_W + TC_MASK_BIT];
        assign err_mask[c] = ch_conf[c*DATA_W + ERR_MASK_BIT];
        assign en_vec[c]   = ch_conf[c*DATA_W];
    end

    assign clr_tc  = (wr_en && dec.hit_glob && dec.gsel == G_CLR_TC)
                     ? bus_wdata[NUM_CH-1:0] : '0;
    assign clr_err = (wr_en && dec.hit_glob && dec.gsel == G_CLR_ERR)
                     ? bus_wdata[NUM_CH-1:0] : '0;

    dma_rf_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_tc    (ev_tc),
        .ev_err   (ev_err),
        .clr_tc   (clr_tc),
        .clr_err  (clr_err),
        .tc_mask  (tc_mask),
        .err_mask (err_mask),
        .tc_raw   (tc_raw_q),
        .err_raw  (err_raw_q),
        .irq_tc   (irq_tc),
        .irq_err  (irq_err),
        .irq_any  (irq_any)
    );

    assign tc_masked  = tc_raw_q  & tc_mask;
    assign err_masked = err_raw_q & err_mask;

    always_comb begin
        rd_val = '0;
        if (dec.hit_glob) begin
            case (dec.gsel)
                G_STAT_ALL: rd_val = {{PAD_W{1'b0}}, tc_masked | err_masked};
                G_STAT_TC:  rd_val = {{PAD_W{1'b0}}, tc_masked};
                G_STAT_ERR: rd_val = {{PAD_W{1'b0}}, err_masked};
                G_RAW_TC:   rd_val = {{PAD_W{1'b0}}, tc_raw_q};
                G_RAW_ERR:  rd_val = {{PAD_W{1'b0}}, err_raw_q};
                G_ENABLED:  rd_val = {{PAD_W{1'b0}}, en_vec};
                G_CONF:     rd_val = DATA_W'(t_q.gconf);
                G_SYNC:     rd_val = t_q.sync;
                default:    rd_val = '0;
            endcase
        end else if (dec.hit_chan) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (dec.chan == 3'(c)) begin
                    case (dec.csel)
                        C_SRC:   rd_val = ch_src [c*DATA_W +: DATA_W];
                        C_DST:   rd_val = ch_dst [c*DATA_W +: DATA_W];
                        C_LINK:  rd_val = ch_link[c*DATA_W +: DATA_W];
                        C_CTRL:  rd_val = ch_ctrl[c*DATA_W +: DATA_W];
                        C_CONF:  rd_val = ch_conf[c*DATA_W +: DATA_W];
                        default: rd_val = '0;
                    endcase
                end
            end
        end
    end

    always_comb begin
        t_d = t_q;
        if (wr_en && dec.hit_glob) begin
            case (dec.gsel)
                G_CONF:  t_d.gconf = bus_wdata[GCONF_W-1:0];
                G_SYNC:  t_d.sync  = bus_wdata;
                default: t_d.sync  = t_q.sync;
            endcase
        end
        if (rd_en) t_d.rdata = rd_val;
        t_d.pulse = (|conf_wr) || (wr_en && dec.hit_glob && dec.gsel == G_CONF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata    = t_q.rdata;
    assign ctrl_enable  = t_q.gconf[0];
    assign cfg_wr_pulse = t_q.pulse;
endmodule

// File: rtl/dma_regfront_chk.sv
module dma_regfront_chk #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] ev_tc,
    input logic              ctrl_enable,
    input logic              cfg_wr_pulse,
    input logic              irq_tc,
    input logic              irq_any,
    input logic [NUM_CH-1:0] tc_raw_q,
    input logic [NUM_CH-1:0] err_raw_q
);
    localparam logic [ADDR_W-1:0] A_CLR_TC = ADDR_W'(2);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_tc) |=> ((tc_raw_q & $past(ev_tc)) == $past(ev_tc)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_CLR_TC && ev_tc == '0)
        |=> ((tc_raw_q & $past(bus_wdata[NUM_CH-1:0])) == '0));

    p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_pulse |-> $past(bus_valid && bus_write));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

    p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> $stable(ctrl_enable));

    p_irq_needs_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_raw_q == '0 && err_raw_q == '0) |-> !irq_any);

    p_tc_needs_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tc |-> (tc_raw_q != '0));
endmodule

bind dma_regfront dma_regfront_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dma_regfront_tb.sv
`timescale 1ns/1ps
module dma_regfront_tb;
    localparam int unsigned NCH  = 8;
    localparam int unsigned NSML = 2;
    localparam int unsigned AW   = 10;
    localparam int unsigned DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [NCH-1:0] ev_tc = '0, ev_err = '0;

    logic [DW-1:0]     rdata, rdata_s;
    logic              en, pulse, ie, it, ia;
    logic              en_s, pulse_s, ie_s, it_s, ia_s;
    logic [NCH*DW-1:0] src, dst, lnk, ctl, cnf;
    logic [NSML*DW-1:0] src_s, dst_s, lnk_s, ctl_s, cnf_s;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_regfront #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .ev_tc(ev_tc), .ev_err(ev_err), .ctrl_enable(en), .cfg_wr_pulse(pulse),
        .ch_src(src), .ch_dst(dst), .ch_link(lnk), .ch_ctrl(ctl), .ch_conf(cnf),
        .irq_err(ie), .irq_tc(it), .irq_any(ia)
    );

    dma_regfront #(.NUM_CH(NSML), .ADDR_W(AW), .DATA_W(DW)) u_small (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
        .ev_tc(ev_tc[NSML-1:0]), .ev_err(ev_err[NSML-1:0]), .ctrl_enable(en_s),
        .cfg_wr_pulse(pulse_s), .ch_src(src_s), .ch_dst(dst_s), .ch_link(lnk_s),
        .ch_ctrl(ctl_s), .ch_conf(cnf_s), .irq_err(ie_s), .irq_tc(it_s), .irq_any(ia_s)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] byte_off, input logic [DW-1:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = AW'(byte_off >> 2); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] byte_off, output logic [DW-1:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(byte_off >> 2);
        @(negedge clk);
        bus_valid = 1'b0;
        data = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] byte_off, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(byte_off, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse_ev(input logic [NCH-1:0] tc, input logic [NCH-1:0] er);
        @(negedge clk);
        ev_tc = tc; ev_err = er;
        @(negedge clk);
        ev_tc = '0; ev_err = '0;
    endtask

    task automatic t_reset;
        chk("R1 irq_any", {31'd0, ia}, 0);
        chk("R1 irq_tc", {31'd0, it}, 0);
        chk("R1 irq_err", {31'd0, ie}, 0);
        chk("R1 enable", {31'd0, en}, 0);
        chk("R1 pulse", {31'd0, pulse}, 0);
        chk("R1 rdata", rdata, 0);
        rd_chk("R1 raw tc", 12'h014, 0);
        rd_chk("R1 ch4 ctrl", 12'h18C, 0);
        rd_chk("R1 sync", 12'h034, 0);
    endtask

    task automatic t_chan_regs;
        wr(12'h160, 32'h1111_0000);
        chk("R10 no pulse on src", {31'd0, pulse}, 0);
        wr(12'h164, 32'h2222_0004);
        wr(12'h168, 32'h3333_0008);
        wr(12'h16C, 32'h4444_000C);
        wr(12'h170, 32'h0000_0A01);
        chk("R10 pulse after chan conf", {31'd0, pulse}, 1);
        @(negedge clk);
        chk("R10 pulse one cycle", {31'd0, pulse}, 0);
        rd_chk("R2 src", 12'h160, 32'h1111_0000);
        rd_chk("R2 dst", 12'h164, 32'h2222_0004);
        rd_chk("R2 link", 12'h168, 32'h3333_0008);
        rd_chk("R2 ctrl", 12'h16C, 32'h4444_000C);
        rd_chk("R2 conf", 12'h170, 32'h0000_0A01);
        chk("R2 src port", src[3*DW +: DW], 32'h1111_0000);
        chk("R2 link port", lnk[3*DW +: DW], 32'h3333_0008);
        chk("R2 conf port", cnf[3*DW +: DW], 32'h0000_0A01);
        chk("R2 ch2 untouched", dst[2*DW +: DW], 0);
        wr(12'h170, 32'h0);
    endtask

    task automatic t_undefined;
        wr(12'h174, 32'hFFFF_FFFF);
        rd_chk("R3 window word5", 12'h174, 0);
        rd_chk("R3 neighbour link", 12'h168, 32'h3333_0008);
        rd_chk("R3 neighbour conf", 12'h170, 0);
        wr(12'h020, 32'hFFFF_FFFF);
        rd_chk("R3 global 0x20", 12'h020, 0);
        wr(12'h040, 32'hFFFF_FFFF);
        rd_chk("R3 global 0x40", 12'h040, 0);
        rd_chk("R3 0x200", 12'h200, 0);
        rd_chk("R3 sync untouched", 12'h034, 0);
        wr(12'h140, 32'hABCD_1234);
        rd_chk("R2 big ch2 src", 12'h140, 32'hABCD_1234);
        chk("R3 small ch2 reads zero", rdata_s, 0);
        wr(12'h150, 32'h1);
        chk("R10 big pulse ch2 conf", {31'd0, pulse}, 1);
        chk("R10 small no pulse out of range", {31'd0, pulse_s}, 0);
        rd_chk("R3 big enabled", 12'h01C, 32'h04);
        chk("R3 small enabled", rdata_s, 0);
        wr(12'h150, 32'h0);
    endtask

    task automatic t_masks_irq;
        pulse_ev(8'h22, 8'h04);
        rd_chk("R12 raw tc", 12'h014, 32'h22);
        rd_chk("R12 raw err", 12'h018, 32'h04);
        rd_chk("R6 masked tc off", 12'h004, 0);
        rd_chk("R6 combined off", 12'h000, 0);
        chk("R7 irq_any masked off", {31'd0, ia}, 0);
        wr(12'h130, 32'h0000_8000);
        chk("R7 irq_tc", {31'd0, it}, 1);
        chk("R7 irq_err still low", {31'd0, ie}, 0);
        chk("R7 irq_any", {31'd0, ia}, 1);
        rd_chk("R6 masked tc", 12'h004, 32'h02);
        wr(12'h150, 32'h0000_4000);
        chk("R7 irq_err", {31'd0, ie}, 1);
        rd_chk("R6 masked err", 12'h00C, 32'h04);
        rd_chk("R6 combined", 12'h000, 32'h06);
        chk("R7 small irq_tc", {31'd0, it_s}, 1);
    endtask

    task automatic t_clear;
        wr(12'h008, 32'h02);
        rd_chk("R4 tc partly cleared", 12'h014, 32'h20);
        chk("R4 irq_tc drops", {31'd0, it}, 0);
        chk("R7 irq_any held by err", {31'd0, ia}, 1);
        wr(12'h010, 32'hFF);
        rd_chk("R4 err cleared", 12'h018, 0);
        chk("R7 irq_any low", {31'd0, ia}, 0);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(12'h008 >> 2);
        bus_wdata = 32'h22; ev_tc = 8'h20;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; ev_tc = '0;
        rd_chk("R5 set beats clear", 12'h014, 32'h20);
        wr(12'h008, 32'h20);
        rd_chk("R4 final clear", 12'h014, 0);
    endtask

    task automatic t_enabled;
        wr(12'h110, 32'h1);
        wr(12'h1F0, 32'h0000_8001);
        rd_chk("R8 enabled", 12'h01C, 32'h81);
        chk("R8 small enabled", rdata_s, 32'h01);
    endtask

    task automatic t_global;
        wr(12'h030, 32'hFFFF_FFF6);
        chk("R10 pulse global conf", {31'd0, pulse}, 1);
        chk("R9 endian bits no enable", {31'd0, en}, 0);
        rd_chk("R9 conf readback", 12'h030, 32'h6);
        wr(12'h030, 32'h7);
        chk("R9 enable", {31'd0, en}, 1);
        wr(12'h034, 32'hDEAD_BEEF);
        chk("R10 no pulse on sync", {31'd0, pulse}, 0);
        rd_chk("R9 sync", 12'h034, 32'hDEAD_BEEF);
    endtask

    task automatic t_rdata_hold;
        logic [DW-1:0] v;
        rd(12'h034, v);
        wr(12'h160, 32'h5555_5555);
        @(negedge clk);
        chk("R11 rdata held", rdata, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan_regs();
        t_undefined();
        t_masks_irq();
        t_clear();
        t_set_wins();
        t_enabled();
        t_global();
        t_rdata_hold();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule